// File: doc/BRIEF.md
# Dual-Mode Burst Address Sequencer

This block generates the address sequence for a four-beat burst. A load pulse captures a full address. The two low bits become the start point of a two-bit wraparound beat sequence. The upper bits are held unchanged for the rest of the burst. On each later clock where the active-low advance input is asserted, the low bits move to the next beat.

A static order input selects one of two orders. In interleaved order, each beat is the start value XORed with a beat index. In linear order, each beat is the start value plus the beat index, modulo four. After four advances the address returns to the start value that was loaded.

The block sits beside an address register in a memory front end. It receives a decoded load pulse and an advance enable. It drives the burst address on every cycle. Memory access, chip selection and write control are handled elsewhere.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears. After that edge `addr_out` reads all zeros.
- R2: When `load` is high at a rising edge, `addr_out` equals the `addr_in` sampled at that edge from the following cycle on.
- R3: When `load` and `adv_n` are both asserted at the same edge, the advance is ignored. `addr_out` shows the loaded address, not the next beat.
- R4: When `load` is low and `adv_n` is high at an edge, `addr_out` does not change.
- R5: With `seq_mode` = 1 (interleaved), the low two bits after k advances equal start XOR (k mod 4). For example, start 01 gives 01, 00, 11, 10.
- R6: With `seq_mode` = 0 (linear), the low two bits after k advances equal (start + k) mod 4. For example, start 01 gives 01, 10, 11, 00.
- R7: The fourth advance after a load returns the low bits to the start value, and the sequence repeats from there.
- R8: Bits `addr_out[ADDR_W-1:2]` keep the value captured at the last load, whatever `addr_in` does in between.
- R9: A load in the middle of a burst restarts the sequence at the newly loaded start value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Capture `addr_in` and restart the burst |
| adv_n | input | 1 | Advance to the next beat, active low |
| seq_mode | input | 1 | Burst order: 1 interleaved, 0 linear; held static |
| addr_in | input | ADDR_W | Address presented for capture |
| addr_out | output | ADDR_W | Current burst address |

## Verification
The hardest case to reach is the wrap from the fourth beat back to the start value. It only happens after four uninterrupted advances with no intervening load. It must also be seen for every start value in both orders, because a wrong carry or XOR term can still give a correct first few beats. The directed stimulus therefore runs a full burst of five advances for each of the four start values under each order. It changes `addr_in` on every beat to show that the upper bits stay held. Separate tasks then force a load and an advance onto the same edge, and issue a reload part-way through a burst.

// File: rtl/burst_seq_pkg.sv
// Package: shared types and widths for the burst address sequencer.
// Assumes a four-beat burst, so the beat index is two bits wide.
package burst_seq_pkg;
    localparam int BEAT_W = 2;

    // Encoding of the order select input
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
// Module: counts the beats of a burst since the last load.
// Assumes clear has priority over step; the count wraps modulo 2**W.
module burst_beat_ctr #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    output logic [W-1:0] beat
);
    // Beat index register: restart on clear, increment on step
    always_ff @(posedge clk) begin
        if (!rst_n)      beat <= '0;
        else if (clear)  beat <= '0;
        else if (step)   beat <= beat + 1'b1;
    end

    // R7: the last beat wraps to index zero
    a_r7_beat_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && step && beat == {W{1'b1}}) |=> (beat == '0));

    // R3: a clear in the same cycle as a step still yields index zero
    a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && step) |=> (beat == '0));
endmodule

// File: rtl/burst_order_map.sv
// Module: maps start value and beat index to the low address bits.
// Assumes the order select is static during a burst; purely combinational.
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int W = 2
) (
    input  logic [W-1:0]  start,
    input  logic [W-1:0]  beat,
    input  burst_order_e  order,
    output logic [W-1:0]  low
);
    // Order select: XOR offset for interleaved, modular sum for linear
    always_comb begin
        case (order)
            ORD_INTERLEAVE: low = start ^ beat;
            default:        low = start + beat;
        endcase
    end
endmodule

// File: rtl/burst_addr_seq.sv
// Module: top of the burst address sequencer.
// Captures a full address on load, holds its upper part and steps the
// low two bits through an interleaved or linear four-beat order.
// Assumes seq_mode is static while a burst is in flight.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv_n,
    input  logic              seq_mode,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int HI_W = ADDR_W - BEAT_W;

    logic [HI_W-1:0]   base_hi;
    logic [BEAT_W-1:0] start_lo;
    logic [BEAT_W-1:0] beat_idx;
    logic [BEAT_W-1:0] low_bits;
    logic              step;
    burst_order_e      order_sel;

    assign step      = !adv_n && !load;
    assign order_sel = burst_order_e'(seq_mode);

    // Address capture: upper bits and start value, loaded together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_hi  <= '0;
            start_lo <= '0;
        end else if (load) begin
            base_hi  <= addr_in[ADDR_W-1:BEAT_W];
            start_lo <= addr_in[BEAT_W-1:0];
        end
    end

    burst_beat_ctr #(.W(BEAT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load),
        .step  (step),
        .beat  (beat_idx)
    );

    burst_order_map #(.W(BEAT_W)) u_map (
        .start (start_lo),
        .beat  (beat_idx),
        .order (order_sel),
        .low   (low_bits)
    );

    assign addr_out = {base_hi, low_bits};

    // R2: a load presents the sampled address on the next cycle
    a_r2_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (addr_out == $past(addr_in)));

    // R4: no load and no advance keeps the address (order held static)
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv_n) |=> ((addr_out == $past(addr_out)) || (seq_mode != $past(seq_mode))));

    // R6: a linear advance adds one to the low bits
    a_r6_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv_n && !seq_mode) |=> (seq_mode || (addr_out[1:0] == $past(addr_out[1:0]) + 2'd1)));

    // R5: an interleaved advance always toggles bit 0
    a_r5_inter_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv_n && seq_mode) |=> (!seq_mode || (addr_out[0] != $past(addr_out[0]))));

    // R8: without a load the upper bits stay put
    a_r8_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(addr_out[ADDR_W-1:BEAT_W]));
endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
    localparam int ADDR_W = 17;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load = 1'b0;
    logic              adv_n = 1'b1;
    logic              seq_mode = 1'b1;
    logic [ADDR_W-1:0] addr_in = '0;
    logic [ADDR_W-1:0] addr_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .load(load), .adv_n(adv_n),
        .seq_mode(seq_mode), .addr_in(addr_in), .addr_out(addr_out)
    );

    task automatic check(input string req, input logic [ADDR_W-1:0] got, input logic [ADDR_W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: addr_out=%h expected=%h", req, got, exp);
        end
    endtask

    // One clock: drive at the falling edge, sample just after the rising edge
    task automatic cycle(input logic ld, input logic an, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        load = ld; adv_n = an; addr_in = a;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [1:0] beat_exp(input logic m, input logic [1:0] s, input int k);
        logic [1:0] kk = 2'(k % 4);
        return m ? (s ^ kk) : 2'(s + kk);
    endfunction

    // R1: reset clears the address
    task automatic t_reset();
        @(negedge clk); rst_n = 1'b0; load = 1'b1; addr_in = 17'h1ABCD;
        @(posedge clk); #1;
        check("R1", addr_out, '0);
        @(negedge clk); rst_n = 1'b1; load = 1'b0;
    endtask

    // R2 R5 R6 R7 R8: full burst plus wrap, addr_in scrambled on every beat
    task automatic t_burst(input logic m, input logic [ADDR_W-1:0] a);
        logic [ADDR_W-3:0] hi = a[ADDR_W-1:2];
        seq_mode = m;
        cycle(1'b1, 1'b1, a);
        check("R2", addr_out, a);
        for (int k = 1; k <= 5; k++) begin
            cycle(1'b0, 1'b0, ~a ^ ADDR_W'(k * 37));
            check(m ? "R5" : "R6", addr_out, {hi, beat_exp(m, a[1:0], k)});
            if (k == 4) check("R7", addr_out, a);
            check("R8", {addr_out[ADDR_W-1:2], 2'b00}, {hi, 2'b00});
        end
    endtask

    // R4: advance deasserted holds the beat
    task automatic t_hold();
        logic [ADDR_W-1:0] a = 17'h0F0F2;
        seq_mode = 1'b0;
        cycle(1'b1, 1'b1, a);
        cycle(1'b0, 1'b0, a);
        for (int k = 0; k < 3; k++) begin
            cycle(1'b0, 1'b1, 17'h1FFFF);
            check("R4", addr_out, {a[ADDR_W-1:2], 2'b11});
        end
    endtask

    // R3: load with advance in the same edge shows the loaded address
    task automatic t_load_adv();
        logic [ADDR_W-1:0] a = 17'h12341;
        seq_mode = 1'b1;
        cycle(1'b1, 1'b0, a);
        check("R3", addr_out, a);
        cycle(1'b0, 1'b0, a);
        check("R3", addr_out, {a[ADDR_W-1:2], 2'b00});
    endtask

    // R9: reload part-way restarts from the new start value
    task automatic t_reload();
        logic [ADDR_W-1:0] a = 17'h00A03;
        logic [ADDR_W-1:0] b = 17'h15552;
        seq_mode = 1'b0;
        cycle(1'b1, 1'b1, a);
        cycle(1'b0, 1'b0, a);
        cycle(1'b0, 1'b0, a);
        cycle(1'b1, 1'b0, b);
        check("R9", addr_out, b);
        cycle(1'b0, 1'b0, a);
        check("R9", addr_out, {b[ADDR_W-1:2], 2'b11});
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 4; s++)
                t_burst(1'(m), {15'(13'h1357 + s * 911), 2'(s)});
        t_hold();
        t_load_adv();
        t_reload();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule